// File: doc/BRIEF.md
# Page Write Buffer With Timed Commit

This block gathers the data bytes of one page-write transaction for a byte-wide non-volatile store and writes them into its storage array once the transaction closes. A transaction opens with a 16-bit start address. The block keeps that address's page number and its in-page offset. Each data strobe then stores one byte at the current offset and advances the offset. The offset wraps inside the page, so the address never moves on to the next page.

A stop pulse starts the commit, but only if at least one byte is waiting. During the commit a scanner visits every position of the page and writes only the positions that were loaded. A busy flag stays high for a fixed, parameterised number of cycles that stands in for the write-cycle time. While busy is high, all bus-side requests are refused. An abort pulse, for example one raised when write protection rejects the data, throws the collected bytes away and starts no commit.

The array is a synchronous RAM inside the block. It has a read port so that its contents can be observed. After reset the block sweeps the whole array to FFh and holds busy high while it does so.

Top module: `eeprom_page_commit`

## Requirements
- R1: After reset, busy_o is 1 for exactly DEPTH clock edges (2048 with the defaults) while the array is filled with FFh. After that, every location reads FFh.
- R2: Address bits [5:0] select the byte within a page and bits [6 +: PAGE_BITS] select the page. All higher address bits are ignored on both the load and the read path.
- R3: Each accepted byte is stored at the current offset, and the offset then advances by one. Offset 63 is followed by offset 0 of the same page. A later byte sent to the same offset replaces the earlier one.
- R4: A commit writes only the offsets loaded since the last address load. Every other location keeps its previous contents.
- R5: A stop while idle, with at least one byte loaded (counting a byte strobe in the same cycle), raises busy_o at the next edge. busy_o then stays high for exactly COMMIT_CYCLES edges (100 with the defaults). A stop with nothing loaded leaves busy_o low.
- R6: An abort while idle discards all loaded bytes. A later stop then starts no commit. When abort and stop arrive in the same cycle, abort wins.
- R7: While busy_o is high, address loads, byte strobes, stops and aborts are ignored. Bytes offered then never reach the array and cause no later commit.
- R8: rd_data_o shows the array contents at rd_addr_i one cycle after rd_en_i is sampled.
- R9: An address load clears any bytes loaded earlier in the transaction, so only bytes strobed after the last load are committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_load_i | input | 1 | Opens a transaction at addr_i |
| addr_i | input | ADDR_W | Start address of the transaction |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | End of transaction; requests a commit |
| abort_i | input | 1 | Discards the loaded bytes |
| rd_en_i | input | 1 | Array read request |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | DATA_W | Read data, one cycle after the request |
| busy_o | output | 1 | Reset sweep or commit in progress |

## Verification
Two pairs of events can fall in the same cycle. The first is abort with stop: abort must win, so no commit starts. The bench checks this by busy_o staying low and by reading back the locations the aborted bytes would have written. The second is a byte strobe with stop: the byte must join the commit even when it is the only one. The bench drives that byte as the sole byte of its transaction, then checks the busy length and the read-back value. Requests driven into the middle of a commit are judged by the absence of a second busy period and by unchanged array contents.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

   typedef enum logic [1:0] {
      SEQ_INIT   = 2'd0,
      SEQ_IDLE   = 2'd1,
      SEQ_COMMIT = 2'd2
   } seq_state_e;

   function automatic int unsigned pwb_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pwb_ram.sv
module pwb_ram #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IDX_W  = 11
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              re_i,
   input  logic [IDX_W-1:0]  raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) cells[waddr_i] <= wdata_i;
   end

   always_ff @(posedge clk) begin
      if (re_i) rdata_o <= cells[raddr_i];
   end

endmodule

// File: rtl/pwb_buffer.sv
module pwb_buffer #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned OFS_W     = 6,
   parameter int unsigned PAGE_BITS = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     busy_i,
   input  logic                     done_i,
   input  logic                     load_i,
   input  logic [PAGE_BITS-1:0]     page_in_i,
   input  logic [OFS_W-1:0]         ofs_in_i,
   input  logic                     byte_vld_i,
   input  logic [DATA_W-1:0]        byte_i,
   input  logic                     abort_i,
   input  logic [OFS_W-1:0]         scan_ofs_i,
   output logic [PAGE_BITS-1:0]     page_o,
   output logic                     scan_valid_o,
   output logic [DATA_W-1:0]        scan_data_o,
   output logic                     pending_o
);
   localparam int unsigned LANES = 1 << OFS_W;

   logic [LANES-1:0]  mask_q;
   logic [OFS_W-1:0]  ofs_q;
   logic [PAGE_BITS-1:0] page_q;
   logic [DATA_W-1:0] lane_q [LANES];
   logic              accept;
   logic              byte_ok;

   // Request arbitration: busy blocks all, abort beats load, load beats byte.
   assign accept  = !busy_i;
   assign byte_ok = accept && !abort_i && !load_i && byte_vld_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         ofs_q  <= '0;
         page_q <= '0;
      end else if (done_i) begin
         mask_q <= '0;
      end else if (accept) begin
         if (abort_i) begin
            mask_q <= '0;
         end else if (load_i) begin
            page_q <= page_in_i;
            ofs_q  <= ofs_in_i;
            mask_q <= '0;
         end else if (byte_vld_i) begin
            mask_q[ofs_q] <= 1'b1;
            ofs_q         <= ofs_q + OFS_W'(1);
         end
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (byte_ok && (ofs_q == OFS_W'(g))) lane_q[g] <= byte_i;
      end
   end

   assign page_o       = page_q;
   assign scan_valid_o = mask_q[scan_ofs_i];
   assign scan_data_o  = lane_q[scan_ofs_i];
   assign pending_o    = accept && !abort_i && !load_i && ((|mask_q) || byte_vld_i);

   // R3: offset steps by one per accepted byte, wrapping inside the page
   assert_ofs_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_ok && !done_i) |=> (ofs_q == $past(ofs_q) + OFS_W'(1)));

   // R6: an accepted abort leaves nothing loaded
   assert_abort_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_i && accept) |=> (mask_q == '0));

   // R7: loaded state frozen while a commit runs
   assert_hold_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !done_i) |=> ($stable(mask_q) && $stable(ofs_q) && $stable(page_q)));

   // R9: an address load starts from an empty buffer
   assert_load_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && accept && !abort_i) |=> (mask_q == '0));

endmodule

// File: rtl/pwb_sequencer.sv
module pwb_sequencer
   import pwb_pkg::*;
#(
   parameter int unsigned OFS_W         = 6,
   parameter int unsigned PAGE_BITS     = 5,
   parameter int unsigned COMMIT_CYCLES = 100,
   parameter bit          INIT_ON_RESET = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         stop_i,
   input  logic                         pending_i,
   output logic                         busy_o,
   output logic                         done_o,
   output logic                         init_o,
   output logic                         scan_act_o,
   output logic [OFS_W-1:0]             scan_ofs_o,
   output logic [OFS_W+PAGE_BITS-1:0]   init_idx_o
);
   localparam int unsigned IDX_W      = OFS_W + PAGE_BITS;
   localparam int unsigned DEPTH      = 1 << IDX_W;
   localparam int unsigned PAGE_BYTES = 1 << OFS_W;
   localparam int unsigned CNT_W      = $clog2(pwb_max(DEPTH, COMMIT_CYCLES) + 1);
   localparam seq_state_e  RST_STATE  = INIT_ON_RESET ? SEQ_INIT : SEQ_IDLE;

   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RST_STATE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            SEQ_INIT: begin
               if (cnt_q == CNT_W'(DEPTH - 1)) begin
                  state_q <= SEQ_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            SEQ_IDLE: begin
               if (stop_i && pending_i) begin
                  state_q <= SEQ_COMMIT;
                  cnt_q   <= '0;
               end
            end
            SEQ_COMMIT: begin
               if (cnt_q == CNT_W'(COMMIT_CYCLES - 1)) begin
                  state_q <= SEQ_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: begin
               state_q <= SEQ_IDLE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign busy_o     = (state_q != SEQ_IDLE);
   assign init_o     = (state_q == SEQ_INIT);
   assign done_o     = (state_q == SEQ_COMMIT) && (cnt_q == CNT_W'(COMMIT_CYCLES - 1));
   assign scan_act_o = (state_q == SEQ_COMMIT) && (cnt_q < CNT_W'(PAGE_BYTES));
   assign scan_ofs_o = cnt_q[OFS_W-1:0];
   assign init_idx_o = cnt_q[IDX_W-1:0];

   // R5: a commit ends only when its full cycle count has elapsed
   assert_busy_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && ($past(state_q) == SEQ_COMMIT)) |-> ($past(cnt_q) == CNT_W'(COMMIT_CYCLES - 1)));

   // R1: the reset sweep never resumes once it has finished
   assert_init_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != SEQ_INIT) |=> (state_q != SEQ_INIT));

endmodule

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit #(
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned OFS_W         = 6,
   parameter int unsigned PAGE_BITS     = 5,
   parameter int unsigned COMMIT_CYCLES = 100,
   parameter bit          INIT_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              byte_vld_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              stop_i,
   input  logic              abort_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              busy_o
);
   localparam int unsigned IDX_W      = OFS_W + PAGE_BITS;
   localparam int unsigned PAGE_BYTES = 1 << OFS_W;

   if (IDX_W > ADDR_W) begin : g_bad_addr
      $error("page and offset fields exceed the address width");
   end
   if (COMMIT_CYCLES < PAGE_BYTES) begin : g_bad_commit
      $error("commit interval shorter than one page scan");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("data width must be positive");
   end

   logic                  done;
   logic                  init;
   logic                  scan_act;
   logic [OFS_W-1:0]      scan_ofs;
   logic [IDX_W-1:0]      init_idx;
   logic                  pending;
   logic [PAGE_BITS-1:0]  page;
   logic                  scan_valid;
   logic [DATA_W-1:0]     scan_data;
   logic                  wr_en;
   logic [IDX_W-1:0]      wr_idx;
   logic [DATA_W-1:0]     wr_data;
   logic [IDX_W-1:0]      rd_idx;

   pwb_sequencer #(
      .OFS_W(OFS_W), .PAGE_BITS(PAGE_BITS),
      .COMMIT_CYCLES(COMMIT_CYCLES), .INIT_ON_RESET(INIT_ON_RESET)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .pending_i(pending),
      .busy_o(busy_o), .done_o(done), .init_o(init),
      .scan_act_o(scan_act), .scan_ofs_o(scan_ofs), .init_idx_o(init_idx)
   );

   pwb_buffer #(
      .DATA_W(DATA_W), .OFS_W(OFS_W), .PAGE_BITS(PAGE_BITS)
   ) u_buf (
      .clk(clk), .rst_n(rst_n), .busy_i(busy_o), .done_i(done),
      .load_i(addr_load_i),
      .page_in_i(addr_i[OFS_W +: PAGE_BITS]), .ofs_in_i(addr_i[OFS_W-1:0]),
      .byte_vld_i(byte_vld_i), .byte_i(byte_i), .abort_i(abort_i),
      .scan_ofs_i(scan_ofs), .page_o(page), .scan_valid_o(scan_valid),
      .scan_data_o(scan_data), .pending_o(pending)
   );

   if (INIT_ON_RESET) begin : g_wr_sweep
      always_comb begin
         if (init) begin
            wr_en   = 1'b1;
            wr_idx  = init_idx;
            wr_data = '1;
         end else begin
            wr_en   = scan_act && scan_valid;
            wr_idx  = {page, scan_ofs};
            wr_data = scan_data;
         end
      end
   end else begin : g_wr_plain
      assign wr_en   = scan_act && scan_valid;
      assign wr_idx  = {page, scan_ofs};
      assign wr_data = scan_data;
   end

   assign rd_idx = {rd_addr_i[OFS_W +: PAGE_BITS], rd_addr_i[OFS_W-1:0]};

   pwb_ram #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ram (
      .clk(clk), .we_i(wr_en), .waddr_i(wr_idx), .wdata_i(wr_data),
      .re_i(rd_en_i), .raddr_i(rd_idx), .rdata_o(rd_data_o)
   );

   // R4: the array is written only inside a sweep or commit interval
   assert_wr_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy_o);

   // R5: a busy period begins only after a stop; R6: never after a coincident abort
   assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> ($past(stop_i) && !$past(abort_i)));

endmodule

// File: tb/eeprom_page_commit_test.sv
module eeprom_page_commit_test;
   localparam int DEPTH = 2048;
   localparam int CC    = 100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_load_i = 1'b0;
   logic [15:0] addr_i = '0;
   logic        byte_vld_i = 1'b0;
   logic [7:0]  byte_i = '0;
   logic        stop_i = 1'b0;
   logic        abort_i = 1'b0;
   logic        rd_en_i = 1'b0;
   logic [15:0] rd_addr_i = '0;
   logic [7:0]  rd_data_o;
   logic        busy_o;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   eeprom_page_commit #(
      .ADDR_W(16), .DATA_W(8), .OFS_W(6), .PAGE_BITS(5),
      .COMMIT_CYCLES(CC), .INIT_ON_RESET(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .addr_load_i(addr_load_i), .addr_i(addr_i),
      .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i),
      .abort_i(abort_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o), .busy_o(busy_o)
   );

   // reference model built from the requirements
   logic [7:0]  mem_m [DEPTH];
   logic [7:0]  mbuf [64];
   logic [63:0] mmask = '0;
   logic [4:0]  mpage = '0;
   logic [5:0]  mofs = '0;

   typedef struct {
      logic [7:0]  exp;
      logic [15:0] addr;
      string       req;
   } rd_item_t;

   rd_item_t sb_q [$];
   logic     rd_pend = 1'b0;

   function automatic int idx_of(input logic [15:0] a);
      return int'({a[10:6], a[5:0]});
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: compares read data against the queued expectation
   always @(posedge clk) rd_pend <= rd_en_i;

   always @(negedge clk) begin
      if (rd_pend) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R8 unexpected read", 0, 1);
         end else begin
            rd_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (rd_data_o !== it.exp) begin
               errors++;
               $display("FAIL %s addr=%h actual=%h expected=%h", it.req, it.addr, rd_data_o, it.exp);
            end
         end
      end
   end

   task automatic t_read(input logic [15:0] a, input string req);
      rd_item_t it;
      @(negedge clk);
      it.exp = mem_m[idx_of(a)];
      it.addr = a;
      it.req = req;
      sb_q.push_back(it);
      rd_en_i = 1'b1;
      rd_addr_i = a;
      @(negedge clk);
      rd_en_i = 1'b0;
   endtask

   task automatic t_load(input logic [15:0] a);
      @(negedge clk);
      addr_load_i = 1'b1;
      addr_i = a;
      @(negedge clk);
      addr_load_i = 1'b0;
      mpage = a[10:6];
      mofs = a[5:0];
      mmask = '0;
   endtask

   task automatic m_byte(input logic [7:0] d);
      mbuf[mofs] = d;
      mmask[mofs] = 1'b1;
      mofs = mofs + 6'd1;
   endtask

   task automatic t_byte(input logic [7:0] d);
      @(negedge clk);
      byte_vld_i = 1'b1;
      byte_i = d;
      @(negedge clk);
      byte_vld_i = 1'b0;
      m_byte(d);
   endtask

   task automatic m_commit();
      for (int i = 0; i < 64; i++)
         if (mmask[i]) mem_m[{mpage, 6'(i)}] = mbuf[i];
      mmask = '0;
   endtask

   // counts edges with busy high after a stop sampled at the next edge
   task automatic measure_busy(output int n);
      @(posedge clk);
      #1;
      stop_i = 1'b0;
      byte_vld_i = 1'b0;
      n = busy_o ? 1 : 0;
      while (busy_o) begin
         @(posedge clk);
         #1;
         if (busy_o) n++;
      end
   endtask

   task automatic t_stop(input string req);
      int n;
      bit exp_commit;
      exp_commit = (mmask != '0);
      @(negedge clk);
      stop_i = 1'b1;
      measure_busy(n);
      if (exp_commit) m_commit();
      check(n == (exp_commit ? CC : 0), req, n, exp_commit ? CC : 0);
   endtask

   task automatic expect_idle(input string req);
      for (int i = 0; i < 3; i++) begin
         @(posedge clk);
         #1;
         check(busy_o == 1'b0, req, busy_o, 0);
      end
   endtask

   initial begin
      int n;
      for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
      repeat (3) @(negedge clk);
      check(busy_o == 1'b1, "R1 busy in reset", busy_o, 1);
      rst_n = 1'b1;
      n = 0;
      do begin
         @(posedge clk);
         #1;
         n++;
      end while (busy_o && n < DEPTH + 10);
      check(n == DEPTH, "R1 sweep length", n, DEPTH);
      t_read(16'h0000, "R1 erased low");
      t_read(16'h07FF, "R1 erased high");
      t_read(16'h0415, "R1 erased mid");

      // basic page write, offsets 5..7 of page 4
      t_load(16'h0105);
      t_byte(8'h11); t_byte(8'h22); t_byte(8'h33);
      t_stop("R5 busy length");
      t_read(16'h0104, "R4 untouched before");
      t_read(16'h0105, "R3 first byte");
      t_read(16'h0106, "R3 second byte");
      t_read(16'h0107, "R8 third byte");
      t_read(16'h0108, "R4 untouched after");

      // high address bits ignored
      t_load(16'hF8C2);
      t_byte(8'hA5); t_byte(8'h5A);
      t_stop("R2 busy length");
      t_read(16'h00C2, "R2 page 3 ofs 2");
      t_read(16'h80C3, "R2 alias read");

      // wrap within page 7, 67 bytes starting at offset 62
      t_load(16'h01FE);
      for (int j = 0; j < 67; j++) t_byte(8'(8'h40 + j));
      t_stop("R3 wrap busy length");
      for (int k = 0; k < 64; k++) t_read(16'(16'h01C0 + k), "R3 wrap contents");
      t_read(16'h01BF, "R3 previous page untouched");
      t_read(16'h0200, "R3 next page untouched");

      // partial overwrite leaves gaps intact
      t_load(16'h0104);
      t_byte(8'h77);
      t_stop("R4 busy length");
      t_read(16'h0104, "R4 new byte");
      t_read(16'h0105, "R4 old byte kept");

      // abort then stop
      t_load(16'h0300);
      t_byte(8'hDE); t_byte(8'hAD);
      @(negedge clk); abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
      mmask = '0;
      t_stop("R6 stop after abort");
      t_read(16'h0300, "R6 aborted byte absent");

      // abort coincident with stop
      t_load(16'h0310);
      t_byte(8'hBE);
      @(negedge clk); abort_i = 1'b1; stop_i = 1'b1;
      @(negedge clk); abort_i = 1'b0; stop_i = 1'b0;
      mmask = '0;
      expect_idle("R6 abort beats stop");
      t_read(16'h0310, "R6 coincident abort");

      // stop with nothing loaded
      t_load(16'h0320);
      t_stop("R5 empty stop");

      // byte coincident with stop: byte is the only one and is committed
      t_load(16'h0321);
      @(negedge clk); byte_vld_i = 1'b1; byte_i = 8'hC3; stop_i = 1'b1;
      m_byte(8'hC3);
      measure_busy(n);
      m_commit();
      check(n == CC, "R5 byte with stop", n, CC);
      t_read(16'h0321, "R5 byte with stop data");

      // address reload discards earlier bytes
      t_load(16'h0400);
      t_byte(8'h01);
      t_load(16'h0440);
      t_byte(8'h02);
      t_stop("R9 busy length");
      t_read(16'h0400, "R9 discarded byte");
      t_read(16'h0440, "R9 kept byte");

      // requests during busy are ignored
      t_load(16'h0500);
      t_byte(8'h99);
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
      m_commit();
      @(negedge clk); addr_load_i = 1'b1; addr_i = 16'h0600;
      @(negedge clk); addr_load_i = 1'b0; byte_vld_i = 1'b1; byte_i = 8'h66;
      @(negedge clk); byte_vld_i = 1'b0; stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
      check(busy_o == 1'b1, "R7 still busy", busy_o, 1);
      while (busy_o) @(negedge clk);
      expect_idle("R7 no second commit");
      t_read(16'h0500, "R7 real commit");
      t_read(16'h0600, "R7 busy byte absent");
      t_read(16'h0501, "R7 busy byte not at old offset");

      repeat (4) @(negedge clk);
      check(sb_q.size() == 0, "R8 all reads returned", sb_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(5.0 * 60000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule